// File: doc/BRIEF.md
# Activity Counter Enable Bank

This block keeps four event counters and one shared enable bit for each of them. Software changes the enable state through a single register port. The port offers two 64-bit views of the same state. In the set view, every 1 written turns a counter on. In the clear view, every 1 written turns a counter off. A 0 written in either view leaves that counter as it was. A read through either view returns the live enable bits in the low four positions and zero in every other position.

Each counter has an event input. A counter adds one on each clock edge where its event input is high and its enable bit is already 1. The counter wraps to zero when it passes its largest value. A separate index input chooses one counter, and that counter's value appears on a 64-bit readout. The readout follows the index in the same cycle.

Top module: `actmon_bank`

## Requirements
- R1: After a synchronous reset, all four enable bits are 0 and every counter holds zero.
- R2: A write (select and write-enable high) with the view input at 0 (set view) makes enable bit n equal to 1 for every write-data bit n in [3:0] that is 1. Bits written as 0 leave their enable unchanged.
- R3: A write with the view input at 1 (clear view) makes enable bit n equal to 0 for every write-data bit n in [3:0] that is 1. Bits written as 0 leave their enable unchanged.
- R4: A read (select high, write-enable low) returns the enable bits on read-data [3:0], with bit n for counter n. The value is the same whichever view is selected.
- R5: Read-data bits [15:4] are always 0, and write-data bits [15:4] have no effect on any state.
- R6: Read-data bits [63:16] are always 0, and write-data bits [63:16] have no effect on any state.
- R7: Counter n adds exactly one at a clock edge when its enable bit (the value before that edge) is 1 and event input n is high. Otherwise it holds its value.
- R8: A counter at its all-ones value that adds one becomes zero (modulo 2^CTR_W, 64 bits by default).
- R9: The counter readout shows, zero-extended to 64 bits, the counter picked by the 2-bit index in the same cycle.
- R10: Read data is all zeros in any cycle that is not a read, that is, when select is low or write-enable is high.
- R11: A cycle without select, or without write-enable, leaves every enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_view | input | 1 | 0 = set view, 1 = clear view |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (enable bits in [3:0]) |
| evt_in | input | 4 | Per-counter event inputs |
| ctr_idx | input | 2 | Selects the counter shown on ctr_value |
| ctr_value | output | 64 | Selected counter value, zero-extended |

## Verification
Some behaviours are checked by assertions on every cycle. These are:
- the write-one-to-set and write-one-to-clear effects one edge after a write;
- enable bits staying stable when no write occurs;
- the zero read-data fields;
- the one-step increment rule for each counter, which also covers the wrap.

Some behaviours only the bench's scenarios can show. These are:
- that both views really return the same readback at the ports;
- that the index steers the readout to the right counter;
- that a counter wraps after a long run of events.

The bench uses a narrow counter width so that the wrap happens within a short run.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

    localparam int unsigned REG_W   = 64;
    localparam int unsigned NUM_CTR = 4;
    localparam int unsigned IDX_W   = $clog2(NUM_CTR);
    localparam int unsigned RAZ_LO  = NUM_CTR;
    localparam int unsigned RAZ_HI  = 15;

    typedef enum logic {
        VIEW_SET = 1'b0,
        VIEW_CLR = 1'b1
    } view_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        view_e            view;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic [NUM_CTR-1:0] set_m;
        logic [NUM_CTR-1:0] clr_m;
    } en_upd_t;

    function automatic logic [REG_W-1:0] pack_enables(input logic [NUM_CTR-1:0] en);
        logic [REG_W-1:0] r;
        r = '0;
        r[NUM_CTR-1:0] = en;
        return r;
    endfunction

endpackage

// File: rtl/actmon_reg_decode.sv
module actmon_reg_decode
    import actmon_pkg::*;
(
    input  reg_req_t req,
    output en_upd_t  upd,
    output logic     rd_active
);
    logic wr_hit;

    always_comb begin
        wr_hit    = req.sel && req.wr;
        rd_active = req.sel && !req.wr;
        upd.set_m = '0;
        upd.clr_m = '0;
        if (wr_hit) begin
            if (req.view == VIEW_SET) begin
                upd.set_m = req.wdata[NUM_CTR-1:0];
            end else begin
                upd.clr_m = req.wdata[NUM_CTR-1:0];
            end
        end
    end
endmodule

// File: rtl/actmon_enable_bank.sv
module actmon_enable_bank
    import actmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  en_upd_t            upd,
    output logic [NUM_CTR-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            // clearing takes precedence over setting the same bit
            en_q <= (en_q | upd.set_m) & ~upd.clr_m;
        end
    end
endmodule

// File: rtl/actmon_counter.sv
module actmon_counter #(
    parameter int unsigned CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CTR_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CTR_W'(1);
        end
    end
endmodule

// File: rtl/actmon_readmux.sv
module actmon_readmux
    import actmon_pkg::*;
#(
    parameter int unsigned CTR_W = 64
) (
    input  logic                          rd_active,
    input  logic [NUM_CTR-1:0]            en_q,
    input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q,
    input  logic [IDX_W-1:0]              idx,
    output logic [REG_W-1:0]              rdata,
    output logic [63:0]                   ctr_value
);
    always_comb begin
        rdata = rd_active ? pack_enables(en_q) : '0;
        ctr_value = '0;
        ctr_value[CTR_W-1:0] = cnt_q[idx];
    end
endmodule

// File: rtl/actmon_bank.sv
module actmon_bank
    import actmon_pkg::*;
#(
    parameter int unsigned CTR_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic        reg_view,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic [3:0]  evt_in,
    input  logic [1:0]  ctr_idx,
    output logic [63:0] ctr_value
);
    reg_req_t                      req;
    en_upd_t                       upd;
    logic                          rd_active;
    logic [NUM_CTR-1:0]            en_q;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q;

    always_comb begin
        req.sel   = reg_sel;
        req.wr    = reg_wr;
        req.view  = view_e'(reg_view);
        req.wdata = reg_wdata;
    end

    actmon_reg_decode u_dec (
        .req       (req),
        .upd       (upd),
        .rd_active (rd_active)
    );

    actmon_enable_bank u_en (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .en_q (en_q)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        actmon_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (en_q[i] && evt_in[i]),
            .cnt_q (cnt_q[i])
        );
    end

    actmon_readmux #(.CTR_W(CTR_W)) u_mux (
        .rd_active (rd_active),
        .en_q      (en_q),
        .cnt_q     (cnt_q),
        .idx       (ctr_idx),
        .rdata     (reg_rdata),
        .ctr_value (ctr_value)
    );
endmodule

// File: rtl/actmon_chk.sv
module actmon_chk #(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CTR_W   = 64
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          reg_sel,
    input logic                          reg_wr,
    input logic                          reg_view,
    input logic [63:0]                   reg_wdata,
    input logic [63:0]                   reg_rdata,
    input logic [NUM_CTR-1:0]            evt_in,
    input logic [NUM_CTR-1:0]            en_q,
    input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0 && cnt_q == '0));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && !reg_view) |=>
        ((en_q & $past(reg_wdata[NUM_CTR-1:0])) == $past(reg_wdata[NUM_CTR-1:0])));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr && reg_view) |=>
        ((en_q & $past(reg_wdata[NUM_CTR-1:0])) == '0));

    p_readback_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && !reg_wr) |-> (reg_rdata[NUM_CTR-1:0] == en_q));

    p_raz_r5: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15:NUM_CTR] == '0);

    p_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[63:16] == '0);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_cnt_chk
        // R7 and R8: one-step increment, modulo the counter width
        p_count_r7: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (cnt_q[i] ==
                $past(cnt_q[i]) + CTR_W'($past(en_q[i] && evt_in[i]))));
    end

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && !reg_wr) |-> (reg_rdata == '0));

    p_nowr_r11: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && reg_wr) |=> $stable(en_q));
endmodule

bind actmon_bank actmon_chk #(.NUM_CTR(4), .CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_view  (reg_view),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .en_q      (en_q),
    .cnt_q     (cnt_q)
);

// File: tb/actmon_bank_bench.sv
`timescale 1ns/1ps
module actmon_bank_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_view = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [3:0]  evt_in = '0;
    logic [1:0]  ctr_idx = '0;
    logic [63:0] ctr_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]    m_en;
    logic [CW-1:0] m_cnt [4];

    always #2 clk = ~clk;

    actmon_bank #(.CTR_W(CW)) u_actmon_bank (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_view(reg_view), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .ctr_idx(ctr_idx), .ctr_value(ctr_value)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic sel, input logic wr, input logic view,
                        input logic [63:0] wd, input logic [3:0] ev,
                        input logic [1:0] idx, input string tag);
        logic [63:0] exp_rd;
        logic [63:0] exp_cv;
        reg_sel = sel; reg_wr = wr; reg_view = view; reg_wdata = wd;
        evt_in = ev; ctr_idx = idx;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (m_en[i] && ev[i]) m_cnt[i] = m_cnt[i] + 1'b1;
        end
        if (sel && wr) begin
            if (view) m_en = m_en & ~wd[3:0];
            else      m_en = m_en | wd[3:0];
        end
        @(negedge clk);
        exp_rd = (sel && !wr) ? {60'd0, m_en} : 64'd0;
        exp_cv = {56'd0, m_cnt[idx]};
        chk({tag, " rdata"}, reg_rdata, exp_rd);
        chk({tag, " ctr"}, ctr_value, exp_cv);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        m_en = '0;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state through both views and every counter
        for (int i = 0; i < 4; i++) step(1, 0, i[0], '0, 4'h0, 2'(i), "R1");

        // R2: set view, then writing zeros changes nothing
        step(1, 1, 0, 64'h5, 4'h0, 0, "R2");
        step(1, 0, 0, '0, 4'h0, 0, "R2");
        step(1, 1, 0, 64'h0, 4'h0, 0, "R2");
        step(1, 0, 1, '0, 4'h0, 0, "R2");

        // R5/R6: reserved write bits ignored, reads zero there
        step(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 4'h0, 0, "R5");
        step(1, 0, 0, '0, 4'h0, 0, "R5");
        step(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0, 4'h0, 0, "R6");
        step(1, 0, 1, '0, 4'h0, 0, "R6");

        // R3 and R4: clear one bit, read via both views
        step(1, 1, 1, 64'h1, 4'h0, 0, "R3");
        step(1, 0, 0, '0, 4'h0, 0, "R4");
        step(1, 0, 1, '0, 4'h0, 0, "R4");
        step(1, 1, 0, 64'hB, 4'h0, 0, "R2");
        step(1, 1, 1, 64'h0, 4'h0, 0, "R3");
        step(1, 0, 1, '0, 4'h0, 0, "R4");

        // R11: write data without select, and read strobes, change nothing
        step(0, 1, 1, 64'hF, 4'h0, 0, "R11");
        step(0, 0, 0, '0, 4'h0, 0, "R11");
        step(1, 0, 0, '0, 4'h0, 0, "R11");

        // R7/R9/R10: mixed event patterns with some counters disabled
        step(1, 1, 1, 64'h2, 4'h0, 0, "R7");
        for (int k = 0; k < 24; k++)
            step(k[2], k[3], 0, '0, 4'(k * 7 + 3), 2'(k), "R7");
        for (int i = 0; i < 4; i++) step(0, 0, 0, '0, 4'h0, 2'(i), "R9");
        step(1, 1, 0, 64'hF, 4'hF, 3, "R10");
        for (int k = 0; k < 8; k++) step(0, 0, 0, '0, 4'hA, 2'(k), "R10");

        // R8: counter 0 runs past its all-ones value
        step(1, 1, 1, 64'hE, 4'h0, 0, "R8");
        for (int k = 0; k < 300; k++) step(0, 0, 0, '0, 4'hF, 0, "R8");
        for (int i = 0; i < 4; i++) step(1, 0, 0, '0, 4'h0, 2'(i), "R8");

        summary();
    end
endmodule